// File: doc/BRIEF.md
# Global Register Bank Selector

This block holds the eight active global registers of a processor core together with several saved copies of them. Software-visible processor state decides which copy is live. Writing the processor-state word, or the global-level register, can select a different copy. When that happens the block stores the live contents into the copy being left and loads the copy being entered, all in a single clock. Reads and writes from the core always go to the live set.

A parameter picks one of two ways of choosing the copy. In flag mode there are four copies, and three processor-state flag bits choose among them. A lone flag picks its own copy. No flag, or any combination of flags, picks the normal copy. In level mode there are eight copies, and a 3-bit level register indexes them directly. In this mode the three flag bits are cleared on every state write and have no effect on bank choice.

Top module: `global_bank_sel`

## Requirements
- R1: After reset every live register, every stored copy, the state word and the level are zero, and bankOut is 0.
- R2: rdData shows live register rdIdx without a clock. A write with wrEn changes register wrIdx at the next edge.
- R3: A state write stores stateWrData AND 0xF3F, and stateOut shows the stored value.
- R4: In flag mode the bank is decoded from state bits 0, 10 and 11. Bit 0 alone selects bank 1, bit 10 alone selects bank 2 and bit 11 alone selects bank 3. No flag, or two or more flags, selects bank 0. bankOut shows the current bank.
- R5: When a write changes the selected bank, the live registers are copied into the outgoing bank and the incoming bank's contents become readable in the next cycle.
- R6: A state or level write that leaves the selected bank unchanged keeps the live contents intact.
- R7: In level mode a level write keeps levelWrData[2:0]. levelOut shows it and the bank equals the level.
- R8: In level mode a state write also clears bits 0, 10 and 11, so the stored mask is 0x33E, and these bits never change the bank.
- R9: In flag mode level writes are ignored. levelOut stays 0 and the bank does not change.
- R10: A register write in the same cycle as a bank change goes into the saved copy of the outgoing bank and does not go into the incoming bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Live register write strobe |
| wrIdx | input | 3 | Live register write index |
| wrData | input | 64 | Live register write data |
| rdIdx | input | 3 | Live register read index |
| rdData | output | 64 | Live register read data |
| stateWrEn | input | 1 | Processor-state write strobe |
| stateWrData | input | 12 | Processor-state write value |
| levelWrEn | input | 1 | Global-level write strobe |
| levelWrData | input | 8 | Global-level write value, upper bits dropped |
| stateOut | output | 12 | Stored processor-state word |
| levelOut | output | 3 | Stored global level |
| bankOut | output | 3 | Currently selected bank |

## Verification
Both variants are driven with identical stimulus, so a level write is checked in flag mode and a flag write is checked in level mode. For every ordered pair of eight codes, the bench goes to a starting bank, fills it with a pattern unique to that pair, and then moves to the target bank. These pairs cover every lone flag, every multi-flag fallback and every repeat of the same bank. They separate a correct save and load from a wrong bank index, a skipped save, and a spurious swap. Further patterns write all-ones to the state word to expose the masks, write a level with junk in its upper bits, and issue a register write in the same cycle as a bank change. The last case shows whether that data reaches the outgoing copy or leaks into the incoming one.

// File: rtl/gbank_pkg.sv
`timescale 1ns/1ps
package gbank_pkg;
  localparam int MAX_BANK_W = 3;
  localparam int PS_W = 12;
  localparam logic [PS_W-1:0] PS_WR_MASK = 12'hF3F;
  localparam logic [PS_W-1:0] PS_FLAG_MASK = 12'hC01;

  typedef struct packed {
    logic wr;
    logic swap;
    logic [MAX_BANK_W-1:0] oldBank;
    logic [MAX_BANK_W-1:0] newBank;
  } gbank_strobe_t;

  // A lone flag picks its own bank; no flag or any mix picks bank 0
  function automatic logic [MAX_BANK_W-1:0] flagBank(input logic [PS_W-1:0] s);
    case ({s[11], s[10], s[0]})
      3'b001:  return 3'd1;
      3'b010:  return 3'd2;
      3'b100:  return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/gbank_ctrl.sv
`timescale 1ns/1ps
module gbank_ctrl
  import gbank_pkg::*;
#(
  parameter int LEVEL_MODE = 0,
  parameter int LVL_IN_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic stateWrEn,
  input  logic [PS_W-1:0] stateWrData,
  input  logic levelWrEn,
  input  logic [LVL_IN_W-1:0] levelWrData,
  output logic [PS_W-1:0] stateOut,
  output logic [MAX_BANK_W-1:0] levelOut,
  output logic [MAX_BANK_W-1:0] bankOut,
  output gbank_strobe_t strobe
);
  localparam logic [PS_W-1:0] WR_MASK =
    (LEVEL_MODE != 0) ? (PS_WR_MASK & ~PS_FLAG_MASK) : PS_WR_MASK;

  logic [PS_W-1:0] stateQ, stateNext;
  logic [MAX_BANK_W-1:0] levelQ, curBank, nextBank;

  assign stateNext = stateWrEn ? (stateWrData & WR_MASK) : stateQ;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateNext;
  end

  generate
    if (LEVEL_MODE != 0) begin : g_level
      logic [MAX_BANK_W-1:0] levelNext;
      logic levelUnused;
      assign levelUnused = ^levelWrData[LVL_IN_W-1:MAX_BANK_W];
      assign levelNext = levelWrEn ? levelWrData[MAX_BANK_W-1:0] : levelQ;
      always_ff @(posedge clk) begin
        if (!rstN) levelQ <= '0;
        else       levelQ <= levelNext;
      end
      assign curBank  = levelQ;
      assign nextBank = levelNext;

      p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
        stateWrEn |=> ((stateOut & PS_FLAG_MASK) == '0) && ($past(levelWrEn) || $stable(bankOut)));
    end else begin : g_flag
      logic levelUnused;
      assign levelUnused = levelWrEn ^ (^levelWrData);
      assign levelQ   = '0;
      assign curBank  = flagBank(stateQ);
      assign nextBank = flagBank(stateNext);
    end
  endgenerate

  always_comb begin
    strobe.wr      = wrEn;
    strobe.swap    = (nextBank != curBank);
    strobe.oldBank = curBank;
    strobe.newBank = nextBank;
  end

  assign stateOut = stateQ;
  assign levelOut = levelQ;
  assign bankOut  = curBank;

  p_state_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut & ~WR_MASK) == '0);

  p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stateWrEn && !levelWrEn) |=> $stable(bankOut));
endmodule

// File: rtl/gbank_dp.sv
`timescale 1ns/1ps
module gbank_dp
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_REGS = 8,
  parameter int BANKS = 4,
  parameter int BANK_W = 2,
  parameter int IDX_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  gbank_strobe_t strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData
);
  typedef logic [NUM_REGS-1:0][DATA_W-1:0] regset_t;

  regset_t activeQ, merged, loadVec;
  regset_t storeQ [BANKS];
  logic [BANK_W-1:0] oldSel, newSel;
  logic bankUnused;

  assign oldSel = strobe.oldBank[BANK_W-1:0];
  assign newSel = strobe.newBank[BANK_W-1:0];
  assign bankUnused = ^{strobe.oldBank, strobe.newBank};

  // Live set with a same-cycle write folded in; this is what gets saved
  always_comb begin
    merged = activeQ;
    if (strobe.wr) merged[wrIdx] = wrData;
  end

  assign loadVec = storeQ[newSel];

  always_ff @(posedge clk) begin
    if (!rstN)            activeQ <= '0;
    else if (strobe.swap) activeQ <= loadVec;
    else                  activeQ <= merged;
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rstN)
          storeQ[b] <= '0;
        else if (strobe.swap && oldSel == BANK_W'(b))
          storeQ[b] <= merged;
      end

      p_save_r10: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.swap && oldSel == BANK_W'(b)) |=> storeQ[b] == $past(merged));
    end
  endgenerate

  assign rdData = activeQ[rdIdx];

  p_swap_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swap |=> activeQ == $past(loadVec));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && !strobe.swap) |=> activeQ[$past(wrIdx)] == $past(wrData));

  p_live_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wr && !strobe.swap) |=> activeQ == $past(activeQ));
endmodule

// File: rtl/global_bank_sel.sv
`timescale 1ns/1ps
module global_bank_sel
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_REGS = 8,
  parameter int LEVEL_MODE = 0,
  parameter int LVL_IN_W = 8,
  localparam int BANKS = (LEVEL_MODE != 0) ? 8 : 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic stateWrEn,
  input  logic [PS_W-1:0] stateWrData,
  input  logic levelWrEn,
  input  logic [LVL_IN_W-1:0] levelWrData,
  output logic [PS_W-1:0] stateOut,
  output logic [MAX_BANK_W-1:0] levelOut,
  output logic [MAX_BANK_W-1:0] bankOut
);
  gbank_strobe_t strobe;

  gbank_ctrl #(.LEVEL_MODE(LEVEL_MODE), .LVL_IN_W(LVL_IN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .stateWrEn(stateWrEn), .stateWrData(stateWrData),
    .levelWrEn(levelWrEn), .levelWrData(levelWrData),
    .stateOut(stateOut), .levelOut(levelOut), .bankOut(bankOut),
    .strobe(strobe)
  );

  gbank_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BANKS(BANKS),
             .BANK_W(BANK_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: tb/sim_global_bank_sel.sv
`timescale 1ns/10ps
module sim_global_bank_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [2:0] rdIdx = '0;
  logic stateWrEn = 1'b0;
  logic [11:0] stateWrData = '0;
  logic levelWrEn = 1'b0;
  logic [7:0] levelWrData = '0;
  logic [63:0] rdData [2];
  logic [11:0] stateOut [2];
  logic [2:0] levelOut [2];
  logic [2:0] bankOut [2];

  int nChecks = 0;
  int nFails = 0;
  logic done = 1'b0;

  logic [63:0] mAct [2][8];
  logic [63:0] mSto [2][8][8];
  logic [11:0] mState [2];
  logic [2:0] mLevel [2];

  always #2 clk = ~clk;

  global_bank_sel #(.LEVEL_MODE(0)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData[0]), .stateWrEn(stateWrEn),
    .stateWrData(stateWrData), .levelWrEn(levelWrEn), .levelWrData(levelWrData),
    .stateOut(stateOut[0]), .levelOut(levelOut[0]), .bankOut(bankOut[0]));

  global_bank_sel #(.LEVEL_MODE(1)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData[1]), .stateWrEn(stateWrEn),
    .stateWrData(stateWrData), .levelWrEn(levelWrEn), .levelWrData(levelWrData),
    .stateOut(stateOut[1]), .levelOut(levelOut[1]), .bankOut(bankOut[1]));

  function automatic logic [2:0] bankOf(int m, logic [11:0] s, logic [2:0] l);
    if (m == 1) return l;
    case ({s[11], s[10], s[0]})
      3'b001:  return 3'd1;
      3'b010:  return 3'd2;
      3'b100:  return 3'd3;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(string req, int m, string what, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s u%0d %s: got %h expected %h", req, m, what, got, exp);
    end
  endtask

  task automatic modelStep(int m, logic wr, logic [2:0] idx, logic [63:0] d,
                           logic sW, logic [11:0] sD, logic lW, logic [7:0] lD);
    logic [11:0] ns;
    logic [2:0] nl, ob, nb;
    logic [63:0] mg [8];
    ns = sW ? (sD & ((m == 1) ? 12'h33E : 12'hF3F)) : mState[m];
    nl = (m == 1 && lW) ? lD[2:0] : mLevel[m];
    ob = bankOf(m, mState[m], mLevel[m]);
    nb = bankOf(m, ns, nl);
    for (int i = 0; i < 8; i++) mg[i] = mAct[m][i];
    if (wr) mg[idx] = d;
    if (ob != nb) begin
      for (int i = 0; i < 8; i++) mSto[m][ob][i] = mg[i];
      for (int i = 0; i < 8; i++) mAct[m][i] = mSto[m][nb][i];
    end else begin
      for (int i = 0; i < 8; i++) mAct[m][i] = mg[i];
    end
    mState[m] = ns;
    mLevel[m] = nl;
  endtask

  // Inputs change 1 ns after a rising edge; the model advances with the edge
  task automatic step(logic wr, logic [2:0] idx, logic [63:0] d,
                      logic sW, logic [11:0] sD, logic lW, logic [7:0] lD);
    wrEn = wr; wrIdx = idx; wrData = d;
    stateWrEn = sW; stateWrData = sD; levelWrEn = lW; levelWrData = lD;
    @(posedge clk);
    for (int m = 0; m < 2; m++) modelStep(m, wr, idx, d, sW, sD, lW, lD);
    #1;
    wrEn = 1'b0; stateWrEn = 1'b0; levelWrEn = 1'b0;
  endtask

  task automatic checkAll(string req);
    for (int i = 0; i < 8; i++) begin
      rdIdx = 3'(i);
      #0.1;
      for (int m = 0; m < 2; m++)
        chk(req, m, $sformatf("reg%0d", i), rdData[m], mAct[m][i]);
    end
    for (int m = 0; m < 2; m++) begin
      chk(req, m, "state", 64'(stateOut[m]), 64'(mState[m]));
      chk(req, m, "level", 64'(levelOut[m]), 64'(mLevel[m]));
      chk(req, m, "bank", 64'(bankOut[m]), 64'(bankOf(m, mState[m], mLevel[m])));
    end
  endtask

  function automatic logic [11:0] flagCode(int a);
    logic [2:0] c;
    c = 3'(a);
    return {c[2], c[1], 4'b0000, 6'b110000} | {11'b0, c[0]} | 12'h0C0;
  endfunction

  initial begin
    for (int m = 0; m < 2; m++) begin
      mState[m] = '0; mLevel[m] = '0;
      for (int i = 0; i < 8; i++) begin
        mAct[m][i] = '0;
        for (int b = 0; b < 8; b++) mSto[m][b][i] = '0;
      end
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkAll("R1 reset");

    // R2: plain writes to the live set without a bank change
    for (int i = 0; i < 8; i++)
      step(1'b1, 3'(i), {32'hC0DE0000, 32'(i * 17)}, 1'b0, '0, 1'b0, '0);
    checkAll("R2 write/read");

    // R4 R5 R6 R7: every ordered pair of codes; flag codes for u0, levels for u1
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        step(1'b0, '0, '0, 1'b1, flagCode(a), 1'b1, 8'(a));
        for (int i = 0; i < 8; i++)
          step(1'b1, 3'(i), {16'hB00C, 16'(a), 16'(b), 16'(i)}, 1'b0, '0, 1'b0, '0);
        step(1'b0, '0, '0, 1'b1, flagCode(b), 1'b1, 8'(b));
        checkAll("R4 R5 R6 R7 pair");
      end
    end

    // R3 R8: all-ones state write exposes the masks
    step(1'b0, '0, '0, 1'b1, 12'hFFF, 1'b0, '0);
    checkAll("R3 R8 mask");
    chk("R3", 0, "stateOut", 64'(stateOut[0]), 64'h000_0000_0000_0F3F);
    chk("R8", 1, "stateOut", 64'(stateOut[1]), 64'h33E);

    // R8: flag-only state writes in level mode leave the bank alone
    step(1'b0, '0, '0, 1'b1, 12'h001, 1'b0, '0);
    checkAll("R8 flag write");
    step(1'b0, '0, '0, 1'b1, 12'h800, 1'b0, '0);
    checkAll("R8 flag write");

    // R7 R9: level value with junk in the upper bits
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 8'hFD);
    checkAll("R7 R9 level");
    chk("R7", 1, "levelOut", 64'(levelOut[1]), 64'd5);
    chk("R9", 0, "levelOut", 64'(levelOut[0]), 64'd0);

    // R10: a write in the same cycle as a bank change
    step(1'b0, '0, '0, 1'b1, 12'h000, 1'b1, 8'h02);
    step(1'b1, 3'd4, 64'h1111_2222_3333_4444, 1'b0, '0, 1'b0, '0);
    step(1'b1, 3'd5, 64'hDEAD_BEEF_0510_0510, 1'b1, 12'h400, 1'b1, 8'h06);
    checkAll("R10 incoming clean");
    step(1'b0, '0, '0, 1'b1, 12'h000, 1'b1, 8'h02);
    checkAll("R10 outgoing saved");
    rdIdx = 3'd5;
    #0.1;
    chk("R10", 0, "reg5", rdData[0], 64'hDEAD_BEEF_0510_0510);
    chk("R10", 1, "reg5", rdData[1], 64'hDEAD_BEEF_0510_0510);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule